// File: doc/BRIEF.md
# Serial DAC Bank Update Controller

This block updates a bank of dual-output 12-bit serial DACs. All chips share one data line and one serial clock. Each chip has its own active-low select. One optional active-low load line is common to all chips. Channel codes are kept in a small internal register file, written through a simple write port. A start pulse carries a channel count, a gain choice and a latch flag.

On the start pulse the controller walks the channels in ascending order and sends one 16-bit command frame per channel. Each frame is framed by the select of the chip that owns the channel. When latching is requested, the controller then waits a set number of cycles and drives one timed low pulse on the load line, so that every output changes at the same moment. A second operation sends a power-down frame to each chip in turn.

The serial clock rate and the two load-line timings are set by clock-cycle parameters. The busy flag covers the whole operation.

Top module: `dacbank_ctrl`

## Requirements
- R1: Each frame is 16 bits, sent most significant bit first, in SPI mode 0. The serial clock idles low while no select is low. The data line changes only while the clock is low, so the chip samples it on the rising edge. There are exactly 16 rising edges per select assertion.
- R2: After reset, every select is high, the load line is high, the serial clock is low and busy is low.
- R3: Channel i is sent to chip i/2, which is the select bit at index i/2. Even channels carry bit 15 = 0 (output A) and odd channels carry bit 15 = 1 (output B). Channels go out in ascending order, so A always precedes B on a chip.
- R4: A requested count of 0 is treated as 1. A count above twice the chip count is treated as twice the chip count.
- R5: Only the low 12 bits of a stored channel value reach frame bits 11..0. Stored bits 15..12 are discarded.
- R6: At most one select is low at any time, and each select assertion carries exactly one frame.
- R7: When the latch flag is set, the load line stays high through all frames. It then falls exactly GAP_CYC+1 clock cycles after the final select rises and stays low for exactly LOAD_CYC cycles. When the latch flag is clear, no load pulse occurs.
- R8: Bit 14 is 0 and bit 12 (enable) is 1 in every write frame. Bit 13 is 1 for 1x gain and 0 for 2x gain, and one gain applies to the whole batch.
- R9: The shutdown operation sends the frame 0x0000 to chips 0 through N_CHIPS-1 in that order. It produces no load pulse, whatever the latch flag says.
- R10: Busy is high from the cycle after an accepted start until the operation ends. A start pulse seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write strobe |
| wr_addr | input | $clog2(2*N_CHIPS) | Channel index to write |
| wr_data | input | 16 | Channel value (low 12 bits used) |
| start | input | 1 | One-cycle operation request |
| start_count | input | $clog2(2*N_CHIPS+1) | Number of channels to send |
| start_gain2 | input | 1 | 1 selects 2x gain, 0 selects 1x |
| start_latch | input | 1 | Pulse the load line after the batch |
| start_shdn | input | 1 | Run the shutdown operation instead of a write |
| busy | output | 1 | Operation in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data |
| cs_n | output | N_CHIPS | Active-low chip selects, bit i for chip i |
| load_n | output | 1 | Shared active-low load line |

## Verification
The bench decodes every frame at the pins, together with the chip whose select carried it. A mapping fault would send a B code to an A output, swap the chip order or stop one chip short. A count of zero or a count too large must come out as one frame and as a full bank. A design that skipped the clamp would send nothing, or index past the register file.

Stored values with their top bits set would, without masking, corrupt the select and gain bits. The load pulse is timed against the last select edge. An early pulse would latch stale codes, and a short pulse would miss the chip's minimum width.

A start pulse sent in the middle of a batch must leave the frame stream unchanged. A shutdown must never pulse the load line.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 12;
  localparam int SEL_BIT  = 15;
  localparam int GAIN_BIT = 13;
  localparam int EN_BIT   = 12;

  localparam logic [FRAME_W-1:0] CODE_MASK  = FRAME_W'((1 << CODE_W) - 1);
  localparam logic [FRAME_W-1:0] SHDN_FRAME = '0;

  // Command bits of a write frame; the code field is left as zero.
  function automatic logic [FRAME_W-1:0] cmd_bits(input logic out_b, input logic gain2);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[SEL_BIT]  = out_b;
    f[GAIN_BIT] = ~gain2;
    f[EN_BIT]   = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/dacbank_regfile.sv
module dacbank_regfile #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Synchronous write and registered read, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dacbank_shifter.sv
module dacbank_shifter
  import dacbank_pkg::*;
#(
  parameter int N_CHIPS = 4,
  parameter int DIV     = 2,
  localparam int CW     = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1,
  localparam int PW     = $clog2(DIV + 1),
  localparam int BW     = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [CW-1:0]      chip,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               mosi,
  output logic [N_CHIPS-1:0] cs_n,
  output logic               done
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HI, S_LO, S_TAIL} sh_state_t;

  localparam logic [N_CHIPS-1:0] ONE_HOT0 = N_CHIPS'(1);

  sh_state_t          st;
  logic [PW-1:0]      ph;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] sh;
  logic               ph_end;

  assign ph_end = (ph == PW'(DIV - 1));
  assign mosi   = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      ph   <= '0;
      bitn <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      cs_n <= '1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) ph <= ph_end ? '0 : ph + 1'b1;
      case (st)
        S_IDLE: if (go) begin
          sh   <= frame;
          cs_n <= ~(ONE_HOT0 << chip);
          bitn <= '0;
          ph   <= '0;
          st   <= S_LEAD;
        end
        S_LEAD: if (ph_end) begin
          sclk <= 1'b1;
          st   <= S_HI;
        end
        S_HI: if (ph_end) begin
          sclk <= 1'b0;
          if (bitn == BW'(FRAME_W - 1)) begin
            st <= S_TAIL;
          end else begin
            sh   <= {sh[FRAME_W-2:0], 1'b0};
            bitn <= bitn + 1'b1;
            st   <= S_LO;
          end
        end
        S_LO: if (ph_end) begin
          sclk <= 1'b1;
          st   <= S_HI;
        end
        S_TAIL: if (ph_end) begin
          cs_n <= '1;
          sh   <= '0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacbank_seq.sv
module dacbank_seq
  import dacbank_pkg::*;
#(
  parameter int N_CHIPS  = 4,
  parameter int GAP_CYC  = 5,
  parameter int LOAD_CYC = 13,
  parameter bit HAS_LOAD = 1'b1,
  localparam int MAXCH   = 2 * N_CHIPS,
  localparam int NW      = $clog2(MAXCH + 1),
  localparam int AW      = $clog2(MAXCH),
  localparam int CW      = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1,
  localparam int TMAX    = (GAP_CYC > LOAD_CYC) ? GAP_CYC : LOAD_CYC,
  localparam int TW      = $clog2(TMAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NW-1:0]      count,
  input  logic               gain2,
  input  logic               latch,
  input  logic               shdn,
  output logic [AW-1:0]      rd_addr,
  input  logic [FRAME_W-1:0] rd_data,
  output logic               go,
  output logic [CW-1:0]      chip,
  output logic [FRAME_W-1:0] frame,
  input  logic               xfer_done,
  output logic               load_n,
  output logic               busy
);
  typedef enum logic [2:0] {Q_IDLE, Q_FETCH, Q_ISSUE, Q_WAIT, Q_GAP, Q_LOAD} seq_state_t;

  seq_state_t     st;
  logic [NW-1:0]  idx;
  logic [NW-1:0]  last;
  logic [NW-1:0]  count_cl;
  logic [TW-1:0]  cnt;
  logic           is_shdn;
  logic           g2;
  logic           do_latch;

  always_comb begin
    if (count == '0)                count_cl = NW'(1);
    else if (count > NW'(MAXCH))    count_cl = NW'(MAXCH);
    else                            count_cl = count;
  end

  assign rd_addr = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= Q_IDLE;
      idx      <= '0;
      last     <= '0;
      cnt      <= '0;
      is_shdn  <= 1'b0;
      g2       <= 1'b0;
      do_latch <= 1'b0;
      go       <= 1'b0;
      chip     <= '0;
      frame    <= '0;
      load_n   <= 1'b1;
      busy     <= 1'b0;
    end else begin
      go <= 1'b0;
      case (st)
        Q_IDLE: if (start) begin
          busy     <= 1'b1;
          is_shdn  <= shdn;
          g2       <= gain2;
          do_latch <= latch & HAS_LOAD & ~shdn;
          last     <= shdn ? NW'(N_CHIPS - 1) : count_cl - 1'b1;
          idx      <= '0;
          st       <= Q_FETCH;
        end
        Q_FETCH: st <= Q_ISSUE;
        Q_ISSUE: begin
          go <= 1'b1;
          if (is_shdn) begin
            chip  <= CW'(idx);
            frame <= SHDN_FRAME;
          end else begin
            chip  <= CW'(idx >> 1);
            frame <= (rd_data & CODE_MASK) | cmd_bits(idx[0], g2);
          end
          st <= Q_WAIT;
        end
        Q_WAIT: if (xfer_done) begin
          if (idx == last) begin
            if (do_latch) begin
              cnt <= '0;
              st  <= Q_GAP;
            end else begin
              busy <= 1'b0;
              st   <= Q_IDLE;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= Q_FETCH;
          end
        end
        Q_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == TW'(GAP_CYC - 1)) begin
            cnt    <= '0;
            load_n <= 1'b0;
            st     <= Q_LOAD;
          end
        end
        Q_LOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == TW'(LOAD_CYC - 1)) begin
            load_n <= 1'b1;
            busy   <= 1'b0;
            st     <= Q_IDLE;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int N_CHIPS  = 4,
  parameter int SCLK_DIV = 2,
  parameter int GAP_CYC  = 5,
  parameter int LOAD_CYC = 13,
  parameter bit HAS_LOAD = 1'b1,
  localparam int MAXCH   = 2 * N_CHIPS,
  localparam int NW      = $clog2(MAXCH + 1),
  localparam int AW      = $clog2(MAXCH),
  localparam int CW      = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               start,
  input  logic [NW-1:0]      start_count,
  input  logic               start_gain2,
  input  logic               start_latch,
  input  logic               start_shdn,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic [N_CHIPS-1:0] cs_n,
  output logic               load_n
);
  logic [AW-1:0]      rd_addr;
  logic [FRAME_W-1:0] rd_data;
  logic               go;
  logic [CW-1:0]      chip;
  logic [FRAME_W-1:0] frame;
  logic               xfer_done;

  dacbank_regfile #(.DEPTH(MAXCH), .W(FRAME_W)) regs_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  dacbank_seq #(
    .N_CHIPS(N_CHIPS), .GAP_CYC(GAP_CYC), .LOAD_CYC(LOAD_CYC), .HAS_LOAD(HAS_LOAD)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .count(start_count),
    .gain2(start_gain2), .latch(start_latch), .shdn(start_shdn),
    .rd_addr(rd_addr), .rd_data(rd_data), .go(go), .chip(chip),
    .frame(frame), .xfer_done(xfer_done), .load_n(load_n), .busy(busy)
  );

  dacbank_shifter #(.N_CHIPS(N_CHIPS), .DIV(SCLK_DIV)) shift_i (
    .clk(clk), .rst(rst), .go(go), .chip(chip), .frame(frame),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(xfer_done)
  );
endmodule

// File: rtl/dacbank_ctrl_chk.sv
module dacbank_ctrl_chk #(
  parameter int N_CHIPS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               sclk,
  input logic               mosi,
  input logic [N_CHIPS-1:0] cs_n,
  input logic               load_n
);
  // R2: every line at rest whenever no operation runs
  p_idle_lines_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((&cs_n) && load_n && !sclk));

  // R6: never two selects low together
  p_one_select_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R6: a select does not change while it is low
  p_select_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && !(&$past(cs_n))) |-> $stable(cs_n));

  // R1: clock stays low while no chip is selected
  p_sclk_rest_r1: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sclk);

  // R1: data is stable through each clock-high phase
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7: load line low only with every select high
  p_load_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> (&cs_n));

  // R10: a select can be low only inside a busy window
  p_busy_cover_r10: assert property (@(posedge clk) disable iff (rst)
    !(&cs_n) |-> busy);
endmodule

bind dacbank_ctrl dacbank_ctrl_chk #(.N_CHIPS(N_CHIPS)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n), .load_n(load_n)
);

// File: tb/dacbank_ctrl_tb_top.sv
module dacbank_ctrl_tb_top;
  localparam int N     = 4;
  localparam int MAXCH = 2 * N;
  localparam int NW    = $clog2(MAXCH + 1);
  localparam int AW    = $clog2(MAXCH);
  localparam int GAPC  = 5;
  localparam int LOADC = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic start = 1'b0;
  logic [NW-1:0] start_count = '0;
  logic start_gain2 = 1'b0, start_latch = 1'b0, start_shdn = 1'b0;
  logic busy, sclk, mosi, load_n;
  logic [N-1:0] cs_n;

  always #4 clk = ~clk;

  dacbank_ctrl #(.N_CHIPS(N), .SCLK_DIV(2), .GAP_CYC(GAPC), .LOAD_CYC(LOADC), .HAS_LOAD(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_count(start_count), .start_gain2(start_gain2),
    .start_latch(start_latch), .start_shdn(start_shdn), .busy(busy),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .load_n(load_n)
  );

  int nchk = 0, nfail = 0;
  logic [15:0] vals [MAXCH];

  // Pin monitor
  int cyc = 0;
  logic prev_sclk = 1'b0, prev_load = 1'b1, prev_mosi = 1'b0;
  logic [N-1:0] prev_cs = '1;
  logic [15:0] cur;
  int nb, cur_chip;
  int mon_n, bad_bits, multi_cs, mosi_glitch, load_in_frame, npulse;
  int last_rise, lfall, llen;
  logic [15:0] mf [32];
  int mc [32];

  task automatic mon_clear();
    mon_n = 0; bad_bits = 0; multi_cs = 0; mosi_glitch = 0;
    load_in_frame = 0; npulse = 0; last_rise = 0; lfall = 0; llen = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_cs == '1 && cs_n != '1) begin
        nb = 0; cur = '0; cur_chip = -1;
        for (int i = 0; i < N; i++) if (!cs_n[i]) cur_chip = i;
      end
      if ($countones(~cs_n) > 1) multi_cs++;
      if (sclk && prev_sclk && mosi != prev_mosi) mosi_glitch++;
      if (cs_n != '1 && sclk && !prev_sclk) begin
        cur = {cur[14:0], mosi}; nb++;
      end
      if (prev_cs != '1 && cs_n == '1) begin
        if (nb != 16) bad_bits++;
        if (mon_n < 32) begin mf[mon_n] = cur; mc[mon_n] = cur_chip; end
        mon_n++;
        last_rise = cyc;
      end
      if (cs_n != '1 && !load_n) load_in_frame++;
      if (prev_load && !load_n) lfall = cyc;
      if (!prev_load && load_n) begin llen = cyc - lfall; npulse++; end
    end
    prev_sclk = sclk; prev_cs = cs_n; prev_load = load_n; prev_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input int ch, input logic [15:0] v, input bit g2);
    logic [15:0] f;
    f = {4'b0000, v[11:0]};
    f[15] = ch[0];
    f[13] = !g2;
    f[12] = 1'b1;
    return f;
  endfunction

  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int cnt, input bit g2, input bit lat, input bit sd);
    mon_clear();
    @(negedge clk);
    start_count = NW'(cnt); start_gain2 = g2; start_latch = lat; start_shdn = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; start_shdn = 1'b0;
    wait_idle();
  endtask

  task automatic chk_frames(input int n, input bit g2, input string req);
    for (int ch = 0; ch < n; ch++) begin
      chk(mf[ch] == exp_frame(ch, vals[ch], g2), req, $sformatf("frame %0d", ch), mf[ch], exp_frame(ch, vals[ch], g2));
      chk(mc[ch] == ch / 2, "R3", $sformatf("chip of channel %0d", ch), mc[ch], ch / 2);
    end
  endtask

  task automatic t_reset();
    chk(cs_n == '1, "R2", "selects after reset", cs_n, 4'hF);
    chk(load_n == 1'b1, "R2", "load after reset", load_n, 1);
    chk(sclk == 1'b0, "R2", "sclk after reset", sclk, 0);
    chk(busy == 1'b0, "R2", "busy after reset", busy, 0);
  endtask

  task automatic t_full_latch();
    run(MAXCH, 1'b0, 1'b1, 1'b0);
    chk(mon_n == MAXCH, "R3", "frame count full bank", mon_n, MAXCH);
    chk_frames(MAXCH, 1'b0, "R8");
    chk(bad_bits == 0, "R1", "frames without 16 bits", bad_bits, 0);
    chk(mosi_glitch == 0, "R1", "data moved with clock high", mosi_glitch, 0);
    chk(multi_cs == 0, "R6", "overlapping selects", multi_cs, 0);
    chk(npulse == 1, "R7", "load pulses", npulse, 1);
    chk(lfall - last_rise == GAPC + 1, "R7", "select-to-load gap", lfall - last_rise, GAPC + 1);
    chk(llen == LOADC, "R7", "load width", llen, LOADC);
    chk(load_in_frame == 0, "R7", "load low during frame", load_in_frame, 0);
  endtask

  task automatic t_partial_gain2();
    run(3, 1'b1, 1'b0, 1'b0);
    chk(mon_n == 3, "R3", "frame count partial", mon_n, 3);
    chk_frames(3, 1'b1, "R8");
    chk(npulse == 0, "R7", "no load without latch flag", npulse, 0);
  endtask

  task automatic t_clamp();
    run(0, 1'b0, 1'b0, 1'b0);
    chk(mon_n == 1, "R4", "count zero clamps to one", mon_n, 1);
    chk_frames(1, 1'b0, "R4");
    run(15, 1'b0, 1'b0, 1'b0);
    chk(mon_n == MAXCH, "R4", "count above max clamps", mon_n, MAXCH);
    chk_frames(MAXCH, 1'b0, "R4");
  endtask

  task automatic t_mask();
    wr(0, 16'hFFFF); vals[0] = 16'hFFFF;
    wr(1, 16'hF000); vals[1] = 16'hF000;
    run(2, 1'b0, 1'b0, 1'b0);
    chk(mf[0] == 16'h3FFF, "R5", "masked A frame", mf[0], 16'h3FFF);
    chk(mf[1] == 16'hB000, "R5", "masked B frame", mf[1], 16'hB000);
  endtask

  task automatic t_shutdown();
    run(1, 1'b0, 1'b1, 1'b1);
    chk(mon_n == N, "R9", "shutdown frame count", mon_n, N);
    for (int c = 0; c < N; c++) begin
      chk(mf[c] == 16'h0000, "R9", $sformatf("shutdown frame %0d", c), mf[c], 0);
      chk(mc[c] == c, "R9", $sformatf("shutdown chip order %0d", c), mc[c], c);
    end
    chk(npulse == 0, "R9", "no load pulse on shutdown", npulse, 0);
  endtask

  task automatic t_busy_ignore();
    mon_clear();
    @(negedge clk);
    start_count = NW'(MAXCH); start_gain2 = 1'b0; start_latch = 1'b0; start_shdn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    repeat (100) @(negedge clk);
    start_shdn = 1'b1; start_count = NW'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0; start_shdn = 1'b0;
    wait_idle();
    chk(mon_n == MAXCH, "R10", "frames after ignored start", mon_n, MAXCH);
    chk_frames(MAXCH, 1'b0, "R10");
    chk(busy == 1'b0, "R10", "busy clears", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    mon_clear();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < MAXCH; i++) begin
      vals[i] = 16'(16'h1357 * (i + 3)) ^ 16'hC000;
      wr(i, vals[i]);
    end
    t_full_latch();
    t_partial_gain2();
    t_clamp();
    t_shutdown();
    t_busy_ignore();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule